// File: doc/BRIEF.md
# Pipelined Second-Order IIR Section

This block is a general-purpose biquad filter for streaming fixed-point samples. All five feedback and feed-forward coefficients come from input ports, so one instance can be retuned at run time. It can also serve as one stage of a cascade or parallel bank that builds a higher-order response.

The datapath is split into two halves. The pole half computes an intermediate value from the new sample and two stored intermediate values. A right shift then divides that sum by the leading denominator coefficient, which is fixed at 2^FRAC_W. The result is captured in a pipeline register. The zero half then forms the output from that register and its own two-deep delay line. Each stage advances only on a valid sample, so gaps between samples leave the filter state untouched. Both halves saturate their results to the sample width instead of wrapping.

Top module: `iir_biquad`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o is 0 and y_o is 0. Reset clears both delay lines, so the first sample after reset sees zero history.
- R2: valid_o is valid_i delayed by exactly LATENCY = 2 clock cycles. Every accepted sample yields exactly one output, in input order, including for back-to-back samples.
- R3: Pole half, with coefficients in signed Q(16-FRAC_W).FRAC_W and FRAC_W = 14 by default: w[n] = sat(floor((x[n]*2^FRAC_W - a1*w[n-1] - a2*w[n-2]) / 2^FRAC_W)).
- R4: Zero half, using the same coefficient format: y[n] = sat(floor((b0*w[n] + b1*w[n-1] + b2*w[n-2]) / 2^FRAC_W)).
- R5: A cycle with valid_i low changes no filter state. While valid_o is low, y_o holds its last value.
- R6: The saturating function sat() clamps to the range -32768..32767, both for w and for y. Large internal sums never wrap.
- R7: New coefficient values take effect for the next sample accepted after they are applied. The filter state is not cleared. Coefficients must be held stable while a sample is in flight (two cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input sample strobe |
| x_i | input | 16 | Signed input sample |
| a1_i | input | 16 | Signed feedback coefficient for w[n-1] |
| a2_i | input | 16 | Signed feedback coefficient for w[n-2] |
| b0_i | input | 16 | Signed feed-forward coefficient for w[n] |
| b1_i | input | 16 | Signed feed-forward coefficient for w[n-1] |
| b2_i | input | 16 | Signed feed-forward coefficient for w[n-2] |
| valid_o | output | 1 | Output sample strobe |
| y_o | output | 16 | Signed filtered output |

## Verification
A pure-feedback impulse with a half-gain pole checks the shift division and the floor rounding, because the output decays through odd values. A resonant low-pass setting fed with gapped, mixed-sign samples separates a correct per-sample state update from one that advances every clock, and a wrong tap order from a right one. Constant large inputs with growing feedback drive w and y into both rails, which exposes any wrapping. A coefficient swap after draining, followed by a reset in mid-stream, shows that new coefficients keep the old history and that reset clears it.

// File: rtl/iir_biquad_pkg.sv
package iir_biquad_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_COEF_W = 16;
  localparam int unsigned DEF_FRAC_W = 14;
  localparam int unsigned MA_TAPS    = 3;
  // pole register + zero register
  localparam int unsigned LATENCY    = 2;
endpackage

// File: rtl/iir_sat.sv
module iir_sat #(
  parameter int unsigned IN_W  = 34,
  parameter int unsigned OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  val_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam logic signed [IN_W-1:0] MAX_V = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MIN_V = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (val_i > MAX_V)      val_o = MAX_V[OUT_W-1:0];
    else if (val_i < MIN_V) val_o = MIN_V[OUT_W-1:0];
    else                    val_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/iir_ar_stage.sv
module iir_ar_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [COEF_W-1:0] a1_i,
  input  logic signed [COEF_W-1:0] a2_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] w_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned ACC_W  = PROD_W + 2;

  logic signed [DATA_W-1:0] w1_q, w2_q, w_q, w_d;
  logic signed [PROD_W-1:0] p1, p2;
  logic signed [ACC_W-1:0]  x_ext, acc, acc_sh;
  logic                     valid_q;

  assign p1    = a1_i * w1_q;
  assign p2    = a2_i * w2_q;
  assign x_ext = {{(ACC_W-DATA_W-FRAC_W){x_i[DATA_W-1]}}, x_i, {FRAC_W{1'b0}}};
  // critical path: one multiplier, two adders
  assign acc    = x_ext - ACC_W'(p1) - ACC_W'(p2);
  // divide by power-of-two leading coefficient
  assign acc_sh = acc >>> FRAC_W;

  iir_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_sat (.val_i(acc_sh), .val_o(w_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q    <= '0;
      w2_q    <= '0;
      w_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        w1_q <= w_d;
        w2_q <= w1_q;
        w_q  <= w_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign w_o     = w_q;
endmodule

// File: rtl/iir_ma_stage.sv
module iir_ma_stage
  import iir_biquad_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] w_i,
  input  logic signed [COEF_W-1:0] coef_i [MA_TAPS],
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned ACC_W  = PROD_W + 2;

  logic signed [DATA_W-1:0] tap  [MA_TAPS];
  logic signed [DATA_W-1:0] dly_q[MA_TAPS];
  logic signed [PROD_W-1:0] prod [MA_TAPS];
  logic signed [ACC_W-1:0]  acc, acc_sh;
  logic signed [DATA_W-1:0] y_d, y_q;
  logic                     valid_q;

  assign tap[0]   = w_i;
  assign dly_q[0] = '0;

  for (genvar k = 0; k < MA_TAPS; k++) begin : g_tap
    if (k > 0) begin : g_dly
      assign tap[k] = dly_q[k];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      dly_q[k] <= '0;
        else if (valid_i) dly_q[k] <= tap[k-1];
      end
    end
    assign prod[k] = coef_i[k] * tap[k];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < MA_TAPS; k++) acc = acc + ACC_W'(prod[k]);
  end
  assign acc_sh = acc >>> FRAC_W;

  iir_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_sat (.val_i(acc_sh), .val_o(y_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) y_q <= y_d;
    end
  end

  assign valid_o = valid_q;
  assign y_o     = y_q;
endmodule

// File: rtl/iir_biquad.sv
module iir_biquad
  import iir_biquad_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned COEF_W = DEF_COEF_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [COEF_W-1:0] a1_i,
  input  logic signed [COEF_W-1:0] a2_i,
  input  logic signed [COEF_W-1:0] b0_i,
  input  logic signed [COEF_W-1:0] b1_i,
  input  logic signed [COEF_W-1:0] b2_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y_o
);
  logic                     ar_valid;
  logic signed [DATA_W-1:0] ar_w;
  logic signed [COEF_W-1:0] ma_coef [MA_TAPS];

  assign ma_coef[0] = b0_i;
  assign ma_coef[1] = b1_i;
  assign ma_coef[2] = b2_i;

  iir_ar_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_ar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .x_i     (x_i),
    .a1_i    (a1_i),
    .a2_i    (a2_i),
    .valid_o (ar_valid),
    .w_o     (ar_w)
  );

  iir_ma_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_ma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ar_valid),
    .w_i     (ar_w),
    .coef_i  (ma_coef),
    .valid_o (valid_o),
    .y_o     (y_o)
  );
endmodule

// File: rtl/iir_biquad_chk.sv
module iir_biquad_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              ar_valid,
  input logic [DATA_W-1:0] ar_w,
  input logic              valid_o,
  input logic [DATA_W-1:0] y_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < 2'd2) |-> !valid_o);

  a_r2_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  a_r2_stage_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd1 && valid_o) |-> $past(ar_valid));

  a_r5_pipe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd1 && !ar_valid) |-> $stable(ar_w));

  a_r5_output_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd1 && !valid_o) |-> $stable(y_o));
endmodule

bind iir_biquad iir_biquad_chk #(.DATA_W(DATA_W)) i_iir_biquad_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .ar_valid (ar_valid),
  .ar_w     (ar_w),
  .valid_o  (valid_o),
  .y_o      (y_o)
);

// File: tb/test_iir_biquad.sv
`timescale 1ns/1ps
module test_iir_biquad;
  localparam int N_TAB = 12;
  localparam int STIM_X   [N_TAB] = '{1000, -2500, 3000, 0, 0, 7000, -8000, 12000, -32768, 32767, 5, -1};
  localparam int STIM_GAP [N_TAB] = '{0, 2, 0, 1, 0, 3, 0, 0, 1, 0, 2, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] x_i = '0, a1_i = '0, a2_i = '0, b0_i = '0, b1_i = '0, b2_i = '0;
  logic valid_o;
  logic signed [15:0] y_o;

  iir_biquad i_iir_biquad (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .a1_i(a1_i), .a2_i(a2_i), .b0_i(b0_i), .b1_i(b1_i), .b2_i(b2_i),
    .valid_o(valid_o), .y_o(y_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int exp_y [1024];
  int exp_c [1024];
  int wr = 0, rd = 0;
  int last_y = 0;
  longint mw1 = 0, mw2 = 0;
  string tag = "R1";
  bit done = 1'b0;

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic set_coef(int a1, int a2, int b0, int b1, int b2);
    @(negedge clk);
    a1_i = 16'(a1); a2_i = 16'(a2); b0_i = 16'(b0); b1_i = 16'(b1); b2_i = 16'(b2);
  endtask

  // reference from the R3/R4 equations, FRAC_W = 14
  task automatic send(int x, int gap);
    longint acc, w, y;
    @(negedge clk);
    acc = longint'(x) * 16384 - longint'(a1_i) * mw1 - longint'(a2_i) * mw2;
    w   = sat16(acc >>> 14);
    acc = longint'(b0_i) * w + longint'(b1_i) * mw1 + longint'(b2_i) * mw2;
    y   = sat16(acc >>> 14);
    mw2 = mw1; mw1 = w;
    exp_y[wr % 1024] = int'(y);
    exp_c[wr % 1024] = cyc + 2;
    wr++;
    valid_i = 1'b1; x_i = 16'(x);
    @(negedge clk);
    valid_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check("R2 output count", rd, wr);
    rd = wr;
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (rd >= wr) check("R2 spurious output", 1, 0);
        else begin
          check({tag, " value"}, int'(y_o), exp_y[rd % 1024]);
          check("R2 latency", cyc, exp_c[rd % 1024]);
          rd++;
        end
        last_y = int'(y_o);
      end else if (int'(y_o) != last_y) begin
        check("R5 hold when idle", int'(y_o), last_y);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid_o in reset", int'(valid_o), 0);
    check("R1 y_o in reset", int'(y_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid_o after reset", int'(valid_o), 0);
    check("R1 y_o after reset", int'(y_o), 0);

    // R3 impulse through pole 0.5, unity b0
    tag = "R3 impulse";
    set_coef(-8192, 0, 16384, 0, 0);
    send(1001, 0);
    for (int i = 0; i < 6; i++) send(0, 0);
    drain();

    // R4/R5 table: resonant low-pass, gapped stream
    tag = "R4 table";
    set_coef(-19661, 13107, 4096, 8192, 4096);
    for (int i = 0; i < N_TAB; i++) send(STIM_X[i], STIM_GAP[i]);
    drain();

    // R6 positive and negative rails
    tag = "R6 saturation";
    set_coef(-32768, 16384, 32767, 32767, 32767);
    for (int i = 0; i < 4; i++) send(20000, 0);
    set_coef(-32768, 0, 16384, 16384, 0);
    for (int i = 0; i < 4; i++) send(-30000, 0);
    drain();

    // R7 coefficient change keeps history
    tag = "R7 reprogram";
    set_coef(8192, -4096, 16384, -16384, 8192);
    for (int i = 0; i < 5; i++) send(2000 * (i - 2), i % 2);
    drain();

    // R1 mid-stream reset clears state and output
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear y_o", int'(y_o), 0);
    check("R1 async clear valid_o", int'(valid_o), 0);
    mw1 = 0; mw2 = 0; last_y = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    tag = "R1 post-reset impulse";
    set_coef(-8192, 4096, 16384, 8192, 0);
    send(4000, 0);
    send(0, 0);
    send(0, 0);
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule